// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block is the host-visible register window of one channel of a bus-master disk DMA controller. The host reaches it through a byte-addressed port. The two low address bits pick one of four byte registers: the DMA command byte, a view of the controller-wide mode register, the DMA status byte, and this channel's transfer-timing byte. A write to the command byte is passed to the DMA engine as a one-cycle strobe. The status byte has three kinds of bits: bits the host reads and writes plainly, a read-only activity bit, and error and interrupt flags that the host clears by writing a one. The engine sets its status bits through dedicated inputs.

The mode register and both channels' timing bytes are held outside the window, because the controller's two channels share them. The window reads them through input ports. It returns updates as one-cycle write pulses. A mode write carries the full new mode value, with only bits 4 and 5 taken from the host, and the pulse also tells the interrupt logic to re-evaluate. A parameter selects which channel's timing byte the instance serves. Two instances are meant to sit 8 bytes apart in a 16-byte region, with a descriptor-address port 4 bytes after each window.

Top module: `bmdma_window`

## Requirements
- R1: After a synchronous reset the command byte, the status byte, `rd_valid`, `rd_data`, `cmd_stb`, `mode_wr` and `tim_wr` are all zero.
- R2: Only byte accesses (`host_size` = 0) are honoured. A read with `host_size` = 1 returns 0x0000FFFF, and a read with `host_size` = 2 or 3 returns 0xFFFFFFFF. A write of any non-byte size changes no register and raises no strobe.
- R3: `host_addr` value 0 selects the command byte, 1 the mode view, 2 the status byte and 3 the timing byte. A read request answers one cycle later with `rd_valid` high for one cycle and the byte in `rd_data[7:0]`, with the upper bits zero. The value returned is the one held before the request's clock edge.
- R4: A byte write to offset 0 stores the byte as the command. In the next cycle `cmd_stb` is high for exactly one cycle, with `cmd_byte` equal to the written byte.
- R5: Status bits 5 and 6 take the written value on a byte write to offset 2. Status bits 3, 4 and 7 always read 0.
- R6: Status bit 0 (active) is not changed by host writes. `hw_set[0]` sets it and `hw_done` clears it.
- R7: Status bits 1 (error) and 2 (interrupt) are cleared by a host write with a 1 in that bit position and kept by a 0. `hw_set[1]` and `hw_set[2]` set them.
- R8: A `hw_set` bit that is high in the same cycle as a host clear of that status bit, or as `hw_done`, wins: the bit reads 1 afterwards.
- R9: A byte write to offset 1 raises `mode_wr` for one cycle. `mode_wr_val` equals `mode_in` with bits 4 and 5 replaced by the written bits 4 and 5, and all other bits unchanged.
- R10: Offset 3 reads `tim0_in` when `CHAN_SEL` = 0 and `tim1_in` when `CHAN_SEL` = 1. A byte write there raises `tim_wr` for one cycle, with `tim_wr_val` equal to the full written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Byte offset inside the window |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_wbyte | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | HOST_W | Read data |
| hw_set | input | 3 | Engine set requests for status bits 0..2 |
| hw_done | input | 1 | Engine clears the active bit |
| dma_status | output | 8 | Current status byte |
| cmd_stb | output | 1 | One-cycle pulse after a command write |
| cmd_byte | output | 8 | Current command byte |
| mode_in | input | 8 | Shared mode register value |
| mode_wr | output | 1 | Shared mode register update and interrupt re-evaluation pulse |
| mode_wr_val | output | 8 | New shared mode value |
| tim0_in | input | 8 | Channel-0 timing byte |
| tim1_in | input | 8 | Channel-1 timing byte |
| tim_wr | output | 1 | Timing byte update pulse |
| tim_wr_val | output | 8 | New timing byte |

## Verification
A host write to the status byte and an engine set request can land on the same clock edge. This happens when the host clears the error or interrupt flag in the cycle where the engine raises it again, or when an engine set and `hw_done` arrive together on the active bit. The bench drives both directed collisions and random traffic in which `hw_set` and `hw_done` are raised alongside host writes. After each cycle it compares `dma_status` with a reference that first applies the host rule and then the engine set, so the bit must read 1.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 2;
    localparam int NREG    = 2 ** SEL_W;
    localparam int HW_BITS = 3;
    localparam int HALF_W  = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef enum logic [SEL_W-1:0] {
        RS_CMD  = 2'd0,
        RS_MODE = 2'd1,
        RS_STAT = 2'd2,
        RS_TIM  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              byte_ok;
        size_e             size;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] wbyte;
    } access_t;

    localparam logic [BYTE_W-1:0] STAT_RW_MASK   = 8'h60;
    localparam logic [BYTE_W-1:0] STAT_RO_MASK   = 8'h01;
    localparam logic [BYTE_W-1:0] STAT_W1C_MASK  = 8'h06;
    localparam logic [BYTE_W-1:0] MODE_HOST_MASK = 8'h30;

    function automatic logic [BYTE_W-1:0] stat_host_merge(
        input logic [BYTE_W-1:0] old_v,
        input logic [BYTE_W-1:0] wv
    );
        return (wv & STAT_RW_MASK) | (old_v & STAT_RO_MASK) |
               (old_v & ~wv & STAT_W1C_MASK);
    endfunction

    function automatic logic [BYTE_W-1:0] mode_host_merge(
        input logic [BYTE_W-1:0] cur,
        input logic [BYTE_W-1:0] wv
    );
        return (cur & ~MODE_HOST_MASK) | (wv & MODE_HOST_MASK);
    endfunction

endpackage

// File: rtl/bmw_access.sv
module bmw_access
    import bmw_pkg::*;
(
    input  logic              host_req,
    input  logic              host_we,
    input  logic [SEL_W-1:0]  host_addr,
    input  logic [1:0]        host_size,
    input  logic [BYTE_W-1:0] host_wbyte,
    output access_t           acc,
    output logic [NREG-1:0]   wr_en
);

    always_comb begin
        acc.size    = size_e'(host_size);
        acc.byte_ok = (acc.size == SZ_BYTE);
        acc.rd      = host_req && !host_we;
        acc.wr      = host_req && host_we && acc.byte_ok;
        acc.sel     = reg_sel_e'(host_addr);
        acc.wbyte   = host_wbyte;
    end

    // one write enable per register slot
    for (genvar g = 0; g < NREG; g++) begin : g_wen
        assign wr_en[g] = acc.wr && (host_addr == SEL_W'(g));
    end

endmodule

// File: rtl/bmw_status.sv
module bmw_status
    import bmw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [BYTE_W-1:0]  wbyte,
    input  logic [HW_BITS-1:0] hw_set,
    input  logic               hw_done,
    output logic [BYTE_W-1:0]  stat
);

    logic [BYTE_W-1:0] stat_nxt;

    always_comb begin
        stat_nxt = stat;
        if (host_wr) begin
            stat_nxt = stat_host_merge(stat, wbyte);
        end
        if (hw_done) begin
            stat_nxt[0] = 1'b0;
        end
        // engine set requests are applied last so they win
        stat_nxt[HW_BITS-1:0] = stat_nxt[HW_BITS-1:0] | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat <= stat_nxt;
        end
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((stat[HW_BITS-1:0] & $past(hw_set)) == $past(hw_set)));

    assert_active_ro_R6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !hw_set[0] && !hw_done) |=> (stat[0] == $past(stat[0])));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (host_wr && wbyte[2] && !hw_set[2]) |=> !stat[2]);

    assert_rw_bits_R5: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (stat[6:5] == $past(wbyte[6:5])));

endmodule

// File: rtl/bmw_cmd.sv
module bmw_cmd
    import bmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              cmd_stb
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            cmd_stb <= 1'b0;
        end else begin
            cmd_stb <= wr;
            if (wr) begin
                cmd_q <= wbyte;
            end
        end
    end

    assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cmd_stb && cmd_q == $past(wbyte)));

    assert_cmd_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !wr |=> (!cmd_stb && $stable(cmd_q)));

endmodule

// File: rtl/bmdma_window.sv
module bmdma_window
    import bmw_pkg::*;
#(
    parameter int HOST_W   = 32,
    parameter int CHAN_SEL = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [1:0]         host_addr,
    input  logic [1:0]         host_size,
    input  logic [7:0]         host_wbyte,
    output logic               rd_valid,
    output logic [HOST_W-1:0]  rd_data,
    input  logic [2:0]         hw_set,
    input  logic               hw_done,
    output logic [7:0]         dma_status,
    output logic               cmd_stb,
    output logic [7:0]         cmd_byte,
    input  logic [7:0]         mode_in,
    output logic               mode_wr,
    output logic [7:0]         mode_wr_val,
    input  logic [7:0]         tim0_in,
    input  logic [7:0]         tim1_in,
    output logic               tim_wr,
    output logic [7:0]         tim_wr_val
);

    localparam logic CHAN_IS1 = (CHAN_SEL != 0);

    access_t           acc;
    logic [NREG-1:0]   wr_en;
    logic [BYTE_W-1:0] stat;
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] tim_sel;
    logic [BYTE_W-1:0] rd_byte;
    logic [HOST_W-1:0] wide_ones;

    bmw_access u_access (
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_size  (host_size),
        .host_wbyte (host_wbyte),
        .acc        (acc),
        .wr_en      (wr_en)
    );

    bmw_status u_status (
        .clk     (clk),
        .rst     (rst),
        .host_wr (wr_en[RS_STAT]),
        .wbyte   (acc.wbyte),
        .hw_set  (hw_set),
        .hw_done (hw_done),
        .stat    (stat)
    );

    bmw_cmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_en[RS_CMD]),
        .wbyte   (acc.wbyte),
        .cmd_q   (cmd_q),
        .cmd_stb (cmd_stb)
    );

    assign tim_sel    = CHAN_IS1 ? tim1_in : tim0_in;
    assign dma_status = stat;
    assign cmd_byte   = cmd_q;

    always_comb begin
        unique case (acc.sel)
            RS_CMD:  rd_byte = cmd_q;
            RS_MODE: rd_byte = mode_in;
            RS_STAT: rd_byte = stat;
            RS_TIM:  rd_byte = tim_sel;
        endcase
    end

    // all-ones pattern sized by the rejected access width
    always_comb begin
        for (int i = 0; i < HOST_W; i++) begin
            wide_ones[i] = (acc.size != SZ_HALF) || (i < HALF_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            mode_wr     <= 1'b0;
            mode_wr_val <= '0;
            tim_wr      <= 1'b0;
            tim_wr_val  <= '0;
        end else begin
            rd_valid <= acc.rd;
            if (acc.rd) begin
                rd_data <= acc.byte_ok ? HOST_W'(rd_byte) : wide_ones;
            end
            mode_wr <= wr_en[RS_MODE];
            if (wr_en[RS_MODE]) begin
                mode_wr_val <= mode_host_merge(mode_in, acc.wbyte);
            end
            tim_wr <= wr_en[RS_TIM];
            if (wr_en[RS_TIM]) begin
                tim_wr_val <= acc.wbyte;
            end
        end
    end

    assert_wide_write_R2: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_size != 2'd0) |=> (!cmd_stb && !mode_wr && !tim_wr));

    assert_rd_valid_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid == $past(host_req && !host_we));

    assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (host_req && !host_we && host_size == 2'd0) |=> (rd_data[HOST_W-1:BYTE_W] == '0));

    assert_mode_keep_R9: assert property (@(posedge clk) disable iff (rst)
        mode_wr |-> ((mode_wr_val & ~MODE_HOST_MASK) == ($past(mode_in) & ~MODE_HOST_MASK)));

    assert_tim_data_R10: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_size == 2'd0 && host_addr == 2'd3) |=>
            (tim_wr && tim_wr_val == $past(host_wbyte)));

endmodule

// File: tb/bmdma_window_test.sv
module bmdma_window_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_addr = '0, host_size = '0;
    logic [7:0]  host_wbyte = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [2:0]  hw_set = '0;
    logic        hw_done = 1'b0;
    logic [7:0]  dma_status, cmd_byte, mode_wr_val, tim_wr_val;
    logic        cmd_stb, mode_wr, tim_wr;
    logic [7:0]  mode_m = 8'h00, tim0_m = 8'h00, tim1_m = 8'h00;

    logic [7:0]  ref_stat = 8'h00, ref_cmd = 8'h00, ref_mode = 8'h00;
    logic [7:0]  ref_tim0 = 8'h00, ref_tim1 = 8'h00;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    bmdma_window #(.HOST_W(32), .CHAN_SEL(1)) uut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_size(host_size), .host_wbyte(host_wbyte),
        .rd_valid(rd_valid), .rd_data(rd_data), .hw_set(hw_set), .hw_done(hw_done),
        .dma_status(dma_status), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
        .mode_in(mode_m), .mode_wr(mode_wr), .mode_wr_val(mode_wr_val),
        .tim0_in(tim0_m), .tim1_in(tim1_m), .tim_wr(tim_wr), .tim_wr_val(tim_wr_val)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [1:0] a, logic [1:0] sz);
        if (sz == 2'd1) return 32'h0000FFFF;
        if (sz != 2'd0) return 32'hFFFFFFFF;
        case (a)
            2'd0: return {24'h0, ref_cmd};
            2'd1: return {24'h0, ref_mode};
            2'd2: return {24'h0, ref_stat};
            default: return {24'h0, ref_tim1};
        endcase
    endfunction

    // one access cycle plus full comparison against the reference model
    task automatic step(bit req, bit we, logic [1:0] a, logic [1:0] sz,
                        logic [7:0] wd, logic [2:0] hs, bit hd, string tag);
        logic [31:0] exp_rd;
        logic [7:0]  nstat;
        bit          bw;
        @(negedge clk);
        host_req = req; host_we = we; host_addr = a; host_size = sz;
        host_wbyte = wd; hw_set = hs; hw_done = hd;
        exp_rd = exp_read(a, sz);
        bw = req && we && (sz == 2'd0);
        nstat = ref_stat;
        if (bw && a == 2'd2)
            nstat = (wd & 8'h60) | (ref_stat & 8'h01) | (ref_stat & ~wd & 8'h06);
        if (hd) nstat[0] = 1'b0;
        nstat[2:0] = nstat[2:0] | hs;
        @(negedge clk);
        host_req = 1'b0; hw_set = '0; hw_done = 1'b0;
        #1;
        if (mode_wr) mode_m = mode_wr_val;
        if (tim_wr) tim1_m = tim_wr_val;
        ref_stat = nstat;
        chk({tag, " status"}, {24'h0, dma_status}, {24'h0, ref_stat});
        chk({tag, " rvalid"}, {31'h0, rd_valid}, {31'h0, req && !we});
        if (req && !we) chk({tag, " rdata"}, rd_data, exp_rd);
        chk({tag, " cmd_stb"}, {31'h0, cmd_stb}, {31'h0, bw && a == 2'd0});
        if (bw && a == 2'd0) ref_cmd = wd;
        chk({tag, " cmd_byte"}, {24'h0, cmd_byte}, {24'h0, ref_cmd});
        chk({tag, " mode_wr"}, {31'h0, mode_wr}, {31'h0, bw && a == 2'd1});
        if (bw && a == 2'd1) ref_mode = (ref_mode & 8'hCF) | (wd & 8'h30);
        chk({tag, " mode"}, {24'h0, mode_m}, {24'h0, ref_mode});
        chk({tag, " tim_wr"}, {31'h0, tim_wr}, {31'h0, bw && a == 2'd3});
        if (bw && a == 2'd3) ref_tim1 = wd;
        chk({tag, " tim1"}, {24'h0, tim1_m}, {24'h0, ref_tim1});
        chk({tag, " tim0"}, {24'h0, tim0_m}, {24'h0, ref_tim0});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state at the ports
        chk("R1 status", {24'h0, dma_status}, 32'h0);
        chk("R1 cmd", {24'h0, cmd_byte}, 32'h0);
        chk("R1 strobes", {29'h0, cmd_stb, mode_wr, tim_wr}, 32'h0);
        chk("R1 rvalid", {31'h0, rd_valid}, 32'h0);
        chk("R1 rdata", rd_data, 32'h0);
        step(1, 0, 2'd0, 2'd0, 8'h00, 3'b000, 0, "R1 read cmd");

        // R2: non-byte accesses
        step(1, 0, 2'd2, 2'd1, 8'h00, 3'b000, 0, "R2 half read");
        step(1, 0, 2'd0, 2'd2, 8'h00, 3'b000, 0, "R2 word read");
        step(1, 0, 2'd3, 2'd3, 8'h00, 3'b000, 0, "R2 wide read");
        step(1, 1, 2'd0, 2'd2, 8'h5A, 3'b000, 0, "R2 word write cmd");
        step(1, 1, 2'd1, 2'd1, 8'hFF, 3'b000, 0, "R2 half write mode");
        step(1, 1, 2'd3, 2'd2, 8'hFF, 3'b000, 0, "R2 word write tim");
        step(1, 0, 2'd0, 2'd0, 8'h00, 3'b000, 0, "R2 cmd unchanged");

        // R4: command strobe, then quiet
        step(1, 1, 2'd0, 2'd0, 8'h09, 3'b000, 0, "R4 cmd write");
        step(0, 0, 2'd0, 2'd0, 8'h00, 3'b000, 0, "R4 strobe drops");
        step(1, 0, 2'd0, 2'd0, 8'h00, 3'b000, 0, "R3 read cmd");

        // R5: plain bits and always-zero bits
        step(1, 1, 2'd2, 2'd0, 8'hFF, 3'b000, 0, "R5 status all ones");
        step(1, 0, 2'd2, 2'd0, 8'h00, 3'b000, 0, "R5 read status");
        step(1, 1, 2'd2, 2'd0, 8'h20, 3'b000, 0, "R5 status 0x20");

        // R6: active bit
        step(0, 0, 2'd0, 2'd0, 8'h00, 3'b001, 0, "R6 hw sets active");
        step(1, 1, 2'd2, 2'd0, 8'h00, 3'b000, 0, "R6 host write 0");
        step(1, 1, 2'd2, 2'd0, 8'hFF, 3'b000, 0, "R6 host write ff");
        step(0, 0, 2'd0, 2'd0, 8'h00, 3'b000, 1, "R6 done clears");

        // R7: write-one-to-clear
        step(0, 0, 2'd0, 2'd0, 8'h00, 3'b110, 0, "R7 hw sets err irq");
        step(1, 1, 2'd2, 2'd0, 8'h02, 3'b000, 0, "R7 clear err only");
        step(1, 1, 2'd2, 2'd0, 8'h00, 3'b000, 0, "R7 zero keeps irq");
        step(1, 1, 2'd2, 2'd0, 8'h04, 3'b000, 0, "R7 clear irq");

        // R8: collisions
        step(0, 0, 2'd0, 2'd0, 8'h00, 3'b110, 0, "R8 prep");
        step(1, 1, 2'd2, 2'd0, 8'h06, 3'b110, 0, "R8 set beats host clear");
        step(0, 0, 2'd0, 2'd0, 8'h00, 3'b001, 1, "R8 set beats done");
        step(1, 0, 2'd2, 2'd0, 8'h00, 3'b000, 0, "R8 read status");

        // R9: mode view and partial update
        mode_m = 8'h0C; ref_mode = 8'h0C;
        step(1, 0, 2'd1, 2'd0, 8'h00, 3'b000, 0, "R9 read mode");
        step(1, 1, 2'd1, 2'd0, 8'hFF, 3'b000, 0, "R9 write mode ff");
        step(1, 1, 2'd1, 2'd0, 8'h10, 3'b000, 0, "R9 write mode 10");
        step(1, 0, 2'd1, 2'd0, 8'h00, 3'b000, 0, "R9 read back mode");

        // R10: timing byte of the selected channel
        tim0_m = 8'hA5; ref_tim0 = 8'hA5; tim1_m = 8'h11; ref_tim1 = 8'h11;
        step(1, 0, 2'd3, 2'd0, 8'h00, 3'b000, 0, "R10 read tim");
        step(1, 1, 2'd3, 2'd0, 8'h7E, 3'b000, 0, "R10 write tim");
        step(1, 0, 2'd3, 2'd0, 8'h00, 3'b000, 0, "R10 read back tim");

        // R3 R8: random traffic with engine events
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:29] == 3'd0) begin
                mode_m = (mode_m & 8'hF3) | {4'h0, r[27:26], 2'b00};
                ref_mode = mode_m;
            end
            step(r[0] | r[1], r[2], r[4:3], (r[6:5] == 2'd0) ? 2'd1 : ((r[8:7] == 2'd0) ? 2'd2 : 2'd0),
                 r[16:9], (r[19:17] == 3'd0) ? r[22:20] : 3'b000, r[25:23] == 3'd0,
                 "R3 R8 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule